// File: doc/BRIEF.md
# Stack frame and multi-register transfer sequencer

This block executes the stack-related instructions of a 32-bit load/store CPU with sixteen general registers, where the highest register serves as stack pointer (SP, R15) and the next one down as frame pointer (FP, R14). A single `start_i` pulse with an operation code and an 8-bit argument runs one multi-cycle sequence. The sequence reads and writes the register file through one combinational read port and one write port, and moves words through a request/acknowledge memory port. The block can push and pop a register list, build and tear down a function frame, and adjust the stack pointer.

For push and pop, the argument is a register bitmask over one eight-register bank. For frame entry and stack adjust, the argument is a byte quantity divided by four, and the block scales it back up. The block raises `busy_o` for the length of the sequence and pulses `done_o` in the last cycle.

Top module: `stack_seq`

## Requirements
- R1: Operation codes on `op_i`: 0 pop low bank, 1 pop high bank, 2 push low bank, 3 push high bank, 4 frame entry, 5 frame exit, 6 stack adjust, 7 reserved. For pop and push, `imm_i` bit i selects register i (low bank) or register 8+i (high bank).
- R2: Pop handles the selected registers from the lowest index upward. Each one loads the word at the running SP, and the running SP then grows by 4.
- R3: Push handles the selected registers from the highest index downward. For each one the running SP first drops by 4, and then the register's value (as read before the sequence) is stored at it.
- R4: At the end of a push or pop, SP is written once with the original SP minus or plus 4 times the number of selected registers. This final write also overrides a value popped into SP.
- R5: Frame entry stores the old FP at SP−4, sets FP to SP−4, and sets SP to SP − 4·`imm_i`, with `imm_i` taken as unsigned.
- R6: Frame exit loads FP from the word at the old FP and sets SP to old FP + 4.
- R7: Stack adjust sets SP to SP + 4·`imm_i`, with `imm_i` sign-extended.
- R8: A push or pop with an all-zero mask, and the reserved code, raise `done_o` in the cycle after start. They issue no memory request and no register write.
- R9: `busy_o` is high from the cycle after an accepted start through the cycle that carries `done_o`. `done_o` lasts exactly one cycle, and the block is quiet on both ports while idle.
- R10: A `start_i` that arrives while busy is ignored and does not alter the running sequence or its results.
- R11: With L the cycles from a memory request to its acknowledge (L ≥ 1), busy lasts 2+n·L cycles for a pop of n registers and 2+n·(L+1) for a push. Frame entry takes 4+L cycles, frame exit 2+L, and stack adjust 2.
- R12: A memory request holds its address, direction and write data unchanged until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| op_i | input | 3 | Operation code |
| imm_i | input | 8 | Register mask or scaled immediate |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_raddr_o | output | 4 | Register read index |
| rf_rdata_i | input | 32 | Register read data (combinational) |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 4 | Register write index |
| rf_wdata_o | output | 32 | Register write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Word byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge, completes the request |

## Verification
The bench builds the block at its default widths: 32-bit data, sixteen registers and an 8-bit mask. With these widths the high bank holds both FP and SP, so pushing or popping the pointers themselves is reachable. The memory model's acknowledge latency is a bench variable, run at 1 and at 3 cycles. The second setting separates the push and pop cycle formulas and exercises request holding across wait cycles. A full 8-bit frame size drives SP below zero and back.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  typedef enum logic [2:0] {
    OP_POP_LO  = 3'd0,
    OP_POP_HI  = 3'd1,
    OP_PUSH_LO = 3'd2,
    OP_PUSH_HI = 3'd3,
    OP_ENTER   = 3'd4,
    OP_EXIT    = 3'd5,
    OP_ADJ     = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_GET_SP, S_GET_FP, S_PUSH_RD, S_MEM, S_SET_FP, S_FIN, S_NOP
  } state_e;
endpackage

// File: rtl/bit_pick.sv
module bit_pick #(
  parameter int  W    = 8,
  parameter bit  HIGH = 1'b0,
  localparam int IW   = $clog2(W)
) (
  input  logic [W-1:0]  mask_i,
  output logic [IW-1:0] idx_o
);
  generate
    if (HIGH) begin : g_high
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) if (mask_i[i]) idx_o = IW'(i);
      end
    end else begin : g_low
      always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) if (mask_i[i]) idx_o = IW'(i);
      end
    end
  endgenerate
endmodule

// File: rtl/imm_scale.sv
module imm_scale #(
  parameter int XLEN  = 32,
  parameter int MASKW = 8
) (
  input  logic [MASKW-1:0] imm_i,
  output logic [XLEN-1:0]  adj_o,
  output logic [XLEN-1:0]  frame_o
);
  localparam int PADW = XLEN - MASKW - 2;
  assign adj_o   = {{PADW{imm_i[MASKW-1]}}, imm_i, 2'b00};
  assign frame_o = {{PADW{1'b0}}, imm_i, 2'b00};
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int  XLEN  = 32,
  parameter int  NREG  = 16,
  parameter int  MASKW = 8,
  localparam int AW    = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [MASKW-1:0] imm_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [AW-1:0]    rf_raddr_o,
  input  logic [XLEN-1:0]  rf_rdata_i,
  output logic             rf_we_o,
  output logic [AW-1:0]    rf_waddr_o,
  output logic [XLEN-1:0]  rf_wdata_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_ack_i
);
  localparam int IW      = $clog2(MASKW);
  localparam int HI_BASE = NREG - MASKW;
  localparam logic [AW-1:0]   SP_IDX = AW'(NREG - 1);
  localparam logic [AW-1:0]   FP_IDX = AW'(NREG - 2);
  localparam logic [XLEN-1:0] WORD   = XLEN'(4);

  state_e           state_q, state_d;
  op_e              op_q, op_d;
  logic [MASKW-1:0] arg_q, arg_d;
  logic [XLEN-1:0]  sp_q, sp_d, data_q, data_d;

  logic [IW-1:0]    lo_idx, hi_idx;
  logic [XLEN-1:0]  adj_off, frame_sz;
  logic [MASKW-1:0] lo_clr, hi_clr;
  logic [AW-1:0]    bank_base, lo_reg, hi_reg;
  logic             is_pop, is_push, is_hi;

  bit_pick #(.W(MASKW), .HIGH(1'b0)) u_pick_lo (.mask_i(arg_q), .idx_o(lo_idx));
  bit_pick #(.W(MASKW), .HIGH(1'b1)) u_pick_hi (.mask_i(arg_q), .idx_o(hi_idx));
  imm_scale #(.XLEN(XLEN), .MASKW(MASKW)) u_scale (
    .imm_i(arg_q), .adj_o(adj_off), .frame_o(frame_sz)
  );

  assign is_pop    = (op_q == OP_POP_LO)  || (op_q == OP_POP_HI);
  assign is_push   = (op_q == OP_PUSH_LO) || (op_q == OP_PUSH_HI);
  assign is_hi     = (op_q == OP_POP_HI)  || (op_q == OP_PUSH_HI);
  assign bank_base = is_hi ? AW'(HI_BASE) : '0;
  assign lo_reg    = bank_base + AW'(lo_idx);
  assign hi_reg    = bank_base + AW'(hi_idx);
  assign lo_clr    = arg_q & ~(MASKW'(1) << lo_idx);
  assign hi_clr    = arg_q & ~(MASKW'(1) << hi_idx);

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN) || (state_q == S_NOP);
  assign mem_req_o   = (state_q == S_MEM);
  assign mem_we_o    = is_push || (op_q == OP_ENTER);
  assign mem_addr_o  = sp_q;
  assign mem_wdata_o = data_q;

  always_comb begin
    unique case (state_q)
      S_GET_SP:  rf_raddr_o = (op_q == OP_EXIT) ? FP_IDX : SP_IDX;
      S_GET_FP:  rf_raddr_o = FP_IDX;
      S_PUSH_RD: rf_raddr_o = hi_reg;
      default:   rf_raddr_o = SP_IDX;
    endcase
  end

  always_comb begin
    rf_we_o    = 1'b0;
    rf_waddr_o = SP_IDX;
    rf_wdata_o = sp_q;
    unique case (state_q)
      S_MEM: if (mem_ack_i && (is_pop || op_q == OP_EXIT)) begin
        rf_we_o    = 1'b1;
        rf_waddr_o = (op_q == OP_EXIT) ? FP_IDX : lo_reg;
        rf_wdata_o = mem_rdata_i;
      end
      S_SET_FP: begin
        rf_we_o    = 1'b1;
        rf_waddr_o = FP_IDX;
      end
      S_FIN:   rf_we_o = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    arg_d   = arg_q;
    sp_d    = sp_q;
    data_d  = data_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        op_d  = op_e'(op_i);
        arg_d = imm_i;
        if ((op_i == OP_RSVD) || (op_i[2] == 1'b0 && imm_i == '0)) state_d = S_NOP;
        else                                                       state_d = S_GET_SP;
      end
      S_GET_SP: begin
        sp_d = rf_rdata_i;
        unique case (op_q)
          OP_ADJ:   begin sp_d = rf_rdata_i + adj_off; state_d = S_FIN; end
          OP_ENTER: state_d = S_GET_FP;
          OP_PUSH_LO, OP_PUSH_HI: state_d = S_PUSH_RD;
          default:  state_d = S_MEM;
        endcase
      end
      S_GET_FP: begin
        data_d  = rf_rdata_i;
        sp_d    = sp_q - WORD;
        state_d = S_MEM;
      end
      S_PUSH_RD: begin
        data_d  = rf_rdata_i;
        sp_d    = sp_q - WORD;
        arg_d   = hi_clr;
        state_d = S_MEM;
      end
      S_MEM: if (mem_ack_i) begin
        if (is_pop) begin
          sp_d    = sp_q + WORD;
          arg_d   = lo_clr;
          state_d = (lo_clr != '0) ? S_MEM : S_FIN;
        end else if (is_push) begin
          state_d = (arg_q != '0) ? S_PUSH_RD : S_FIN;
        end else if (op_q == OP_ENTER) begin
          state_d = S_SET_FP;
        end else begin
          sp_d    = sp_q + WORD;
          state_d = S_FIN;
        end
      end
      S_SET_FP: begin
        sp_d    = sp_q + WORD - frame_sz;
        state_d = S_FIN;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_RSVD;
      arg_q   <= '0;
      sp_q    <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      arg_q   <= arg_d;
      sp_q    <= sp_d;
      data_q  <= data_d;
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int  XLEN  = 32,
  parameter int  NREG  = 16,
  parameter int  MASKW = 8,
  localparam int AW    = $clog2(NREG)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [2:0]       op_i,
  input logic [MASKW-1:0] imm_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [AW-1:0]    rf_raddr_o,
  input logic [XLEN-1:0]  rf_rdata_i,
  input logic             rf_we_o,
  input logic [AW-1:0]    rf_waddr_o,
  input logic [XLEN-1:0]  rf_wdata_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [XLEN-1:0]  mem_addr_o,
  input logic [XLEN-1:0]  mem_wdata_o,
  input logic [XLEN-1:0]  mem_rdata_i,
  input logic             mem_ack_i
);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_in_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !rf_we_o && !done_o));

  assert_busy_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  assert_req_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_short_no_traffic_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(busy_o)) |-> (!rf_we_o && !mem_req_o));
endmodule

bind stack_seq stack_seq_chk #(.XLEN(XLEN), .NREG(NREG), .MASKW(MASKW)) u_chk (.*);

// File: tb/stack_seq_bench.sv
module stack_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [7:0]  imm_i = 8'd0;
  logic        busy_o, done_o, rf_we_o, mem_req_o, mem_we_o, mem_ack_i;
  logic [3:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o, mem_addr_o, mem_wdata_o, mem_rdata_i;

  logic [31:0] rf [16];
  logic [31:0] mem [256];
  logic [31:0] e_rf [16];
  logic [31:0] e_mem [256];
  logic [31:0] q_addr[$], q_data[$];
  bit          q_we[$];
  int          lat = 1, ack_cnt = 0;
  int          errors = 0, checks = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  stack_seq u_stack_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .op_i(op_i), .imm_i(imm_i),
    .busy_o(busy_o), .done_o(done_o),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  assign rf_rdata_i  = rf[rf_raddr_o];
  assign mem_rdata_i = mem[mem_addr_o[9:2]];
  assign mem_ack_i   = mem_req_o && (ack_cnt == lat - 1);

  always @(posedge clk) begin
    if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
    if (mem_req_o && mem_ack_i && mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
    if (!rst_n || (mem_req_o && mem_ack_i)) ack_cnt <= 0;
    else if (mem_req_o) ack_cnt <= ack_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory transaction order and content (R2 R3 R5 R6 R12)
  always @(negedge clk) begin
    if (rst_n && mem_req_o && mem_ack_i) begin
      if (q_addr.size() == 0) chk(1'b0, "R2/R3 unexpected access", mem_addr_o, 32'hx);
      else begin
        logic [31:0] a, d; bit w;
        a = q_addr.pop_front(); d = q_data.pop_front(); w = q_we.pop_front();
        chk(mem_addr_o == a, "R2/R3 access address", mem_addr_o, a);
        chk(mem_we_o == w, "R2/R3 access direction", {31'd0, mem_we_o}, {31'd0, w});
        if (w) chk(mem_wdata_o == d, "R3/R5 store data", mem_wdata_o, d);
        else   chk(mem_rdata_i == d, "R2/R6 load data", mem_rdata_i, d);
      end
    end
  end

  function automatic int popc(input logic [7:0] m);
    int n = 0;
    for (int i = 0; i < 8; i++) n += m[i];
    return n;
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [7:0] imm, input bit poke, input string tag);
    int ncyc, base;
    logic [31:0] sp;
    for (int i = 0; i < 16; i++) e_rf[i] = rf[i];
    for (int i = 0; i < 256; i++) e_mem[i] = mem[i];
    base = op[0] ? 8 : 0;
    sp = rf[15];
    ncyc = 1;
    case (op)
      3'd0, 3'd1: if (imm != 0) begin
        for (int i = 0; i < 8; i++) if (imm[i]) begin
          q_addr.push_back(sp); q_we.push_back(0); q_data.push_back(e_mem[sp[9:2]]);
          e_rf[base + i] = e_mem[sp[9:2]];
          sp += 4;
        end
        e_rf[15] = sp;
        ncyc = 2 + popc(imm) * lat;
      end
      3'd2, 3'd3: if (imm != 0) begin
        for (int i = 7; i >= 0; i--) if (imm[i]) begin
          sp -= 4;
          q_addr.push_back(sp); q_we.push_back(1); q_data.push_back(rf[base + i]);
          e_mem[sp[9:2]] = rf[base + i];
        end
        e_rf[15] = sp;
        ncyc = 2 + popc(imm) * (lat + 1);
      end
      3'd4: begin
        q_addr.push_back(sp - 4); q_we.push_back(1); q_data.push_back(rf[14]);
        e_mem[(sp - 32'd4) >> 2 & 32'hff] = rf[14];
        e_rf[14] = sp - 4;
        e_rf[15] = sp - {22'd0, imm, 2'b00};
        ncyc = 4 + lat;
      end
      3'd5: begin
        q_addr.push_back(rf[14]); q_we.push_back(0); q_data.push_back(mem[rf[14][9:2]]);
        e_rf[14] = mem[rf[14][9:2]];
        e_rf[15] = rf[14] + 4;
        ncyc = 2 + lat;
      end
      3'd6: begin
        e_rf[15] = sp + {{22{imm[7]}}, imm, 2'b00};
        ncyc = 2;
      end
      default: ncyc = 1;
    endcase

    @(negedge clk);
    start_i = 1'b1; op_i = op; imm_i = imm;
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      start_i = (poke && c == 1 && ncyc > 1); // R10: request while busy
      op_i = 3'd6; imm_i = 8'h7f;
      chk(busy_o == 1'b1, {tag, " R9/R11 busy"}, {31'd0, busy_o}, 32'd1);
      chk(done_o == (c == ncyc), {tag, " R11 done timing"}, {31'd0, done_o}, {31'd0, c == ncyc});
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o && !done_o, {tag, " R9 idle after done"}, {30'd0, busy_o, done_o}, 32'd0);
    begin
      int bad_r = -1, bad_m = -1;
      for (int i = 0; i < 16; i++) if (rf[i] !== e_rf[i] && bad_r < 0) bad_r = i;
      for (int i = 0; i < 256; i++) if (mem[i] !== e_mem[i] && bad_m < 0) bad_m = i;
      if (bad_r >= 0) chk(1'b0, {tag, " register result"}, rf[bad_r], e_rf[bad_r]);
      else chk(1'b1, tag, 0, 0);
      if (bad_m >= 0) chk(1'b0, {tag, " memory result"}, mem[bad_m], e_mem[bad_m]);
      else chk(1'b1, tag, 0, 0);
    end
    chk(q_addr.size() == 0, {tag, " R2/R3 missing access"}, q_addr.size(), 0);
    q_addr.delete(); q_data.delete(); q_we.delete();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 + i * 32'h0101_0011;
    rf[15] = 32'h200; rf[14] = 32'h380;
    for (int i = 0; i < 256; i++) mem[i] = 32'ha500_0000 + i;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o && !rf_we_o, "R9 reset state",
        {28'd0, busy_o, done_o, mem_req_o, rf_we_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    lat = 1;
    run_op(3'd2, 8'ha5, 0, "R1 R3 R4 push low");
    rf[0] = 0; rf[2] = 0; rf[5] = 0; rf[7] = 0;
    run_op(3'd0, 8'ha5, 0, "R1 R2 R4 pop low round trip");
    run_op(3'd3, 8'hc0, 0, "R1 R3 push fp and sp");
    run_op(3'd1, 8'h80, 0, "R4 pop into sp");
    run_op(3'd2, 8'h00, 0, "R8 empty push");
    run_op(3'd0, 8'h00, 0, "R8 empty pop");
    run_op(3'd7, 8'hff, 0, "R8 reserved");
    run_op(3'd4, 8'h10, 0, "R5 entry");
    run_op(3'd5, 8'h00, 0, "R6 exit");
    run_op(3'd6, 8'hf8, 0, "R7 adjust negative");
    run_op(3'd6, 8'h05, 1, "R7 R10 adjust positive");

    lat = 3;
    run_op(3'd3, 8'hff, 1, "R10 R11 R12 push high full");
    run_op(3'd0, 8'hff, 0, "R11 R12 pop low full");
    run_op(3'd0, 8'h01, 0, "R2 single low");
    run_op(3'd2, 8'h80, 1, "R3 R10 single high bit");
    run_op(3'd4, 8'hff, 1, "R5 R10 entry max frame");
    run_op(3'd5, 8'h00, 0, "R6 exit after max frame");

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule